// File: doc/BRIEF.md
# Interlaced Video Timing Generator

This block produces the raster timing for an interlaced display. A frame is built from two fields that alternate on every vertical period. Each field covers a fixed number of lines, and each line a fixed number of pixel clocks. The block drives horizontal and vertical sync, a field flag that tells odd fields from even ones, a display-active window, and the index of the source line that the pixel path should fetch for the current active line.

A control input picks which field opens a frame. In the second field of every frame, the vertical sync pulse moves by half a line. It moves later when that field is even and earlier when that field is odd. This half-line step is what makes the two fields interlace on the screen. A second control input picks how lines are addressed. In repeat mode, both fields fetch the same source lines. In interleave mode, the even field fetches the even source lines and the odd field fetches the odd ones, so one frame covers twice as many source lines as a single field.

Both control inputs are plain static pins. They are sampled only at reset and at frame boundaries, so the frame in progress always finishes with the settings it started with. The block has no data stream, so it has no handshake.

Top module: `ilace_timing_gen`

## Requirements
- R1: Every line lasts H_TOTAL clock cycles. `hsync_o` is high during pixels 0 to H_SYNC_W-1 of each line and low for the rest of the line.
- R2: Every field lasts V_TOTAL lines. `field_even_o` changes only on the first pixel of a field. It inverts at the boundary between the first and second field of a frame.
- R3: `field_even_o` is 0 during an odd field and 1 during an even field.
- R4: When `even_first_i` is 0, a frame starts with an odd field. When it is 1, a frame starts with an even field. The input is sampled only while reset is high and on the last pixel of a frame, so a change in the middle of a frame applies from the next frame.
- R5: In the first field of a frame, `vsync_o` rises on pixel 0 of line V_SYNC_START and stays high for V_SYNC_LINES*H_TOTAL cycles.
- R6: In the second field of a frame, `vsync_o` lasts the same length but starts at pixel H_TOTAL/2. If that field is even, the pulse starts on line V_SYNC_START. If that field is odd, it starts on line V_SYNC_START-1, which is half a line earlier than the first-field position.
- R7: `disp_act_o` is high only when both of these hold: the line is in V_ACT_START to V_ACT_START+ACT_LINES-1, and the pixel is in H_ACT_START to H_ACT_START+H_ACT_W-1.
- R8: In repeat mode (`interleave_i` = 0), `src_line_o` during active video is the active line number within the field, from 0 to ACT_LINES-1.
- R9: In interleave mode (`interleave_i` = 1), `src_line_o` during active video is 2k in an even field and 2k+1 in an odd field, where k is the active line number within the field.
- R10: `interleave_i` is sampled at the same moments as `even_first_i`: while reset is high and on the last pixel of a frame.
- R11: `src_line_o` is 0 whenever `disp_act_o` is low.
- R12: A synchronous active-high reset puts the generator at pixel 0 of line 0 of the first field of a frame. Right after reset, `field_even_o` equals the `even_first_i` value that was sampled during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| even_first_i | input | 1 | 0: a frame opens with the odd field; 1: a frame opens with the even field |
| interleave_i | input | 1 | 0: both fields fetch the same lines; 1: the fields fetch alternate lines |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high, shifted by half a line in the second field |
| field_even_o | output | 1 | Field flag: 0 for an odd field, 1 for an even field |
| disp_act_o | output | 1 | High inside the active display window |
| src_line_o | output | LINE_W | Source line to fetch; 0 outside the active window |

## Verification
The bench keeps the full 240 active lines and the 9-bit index, so interleave mode reaches source line 479 and repeat mode reaches 239. It shrinks each line to 20 clocks, with a 250-line field and the sync start just below the active region. At that size every pixel of twelve fields (about 60,000 cycles) is compared against arithmetic pixel-position formulas.

Both control inputs toggle at points that do not line up with frames. A second reset with the opposite field order lets the sweep see both orders and both addressing modes at frame starts, and also mid-frame changes that must be ignored.

// File: rtl/ilace_pkg.sv
package ilace_pkg;
  typedef enum logic {
    FLD_FIRST  = 1'b0,
    FLD_SECOND = 1'b1
  } fld_pos_e;
endpackage

// File: rtl/ilace_hcount.sv
module ilace_hcount #(
  parameter int H_TOTAL = 858,
  parameter int HW      = 10
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] hcnt,
  output logic          line_end
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOTAL - 1);

  assign line_end = (hcnt == H_LAST);

  always_ff @(posedge clk) begin
    if (rst)           hcnt <= '0;
    else if (line_end) hcnt <= '0;
    else               hcnt <= hcnt + 1'b1;
  end
endmodule

// File: rtl/ilace_field_seq.sv
module ilace_field_seq
  import ilace_pkg::*;
#(
  parameter int V_TOTAL = 262,
  parameter int VW      = 9
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_end,
  input  logic          even_first_i,
  input  logic          interleave_i,
  output logic [VW-1:0] vcnt,
  output fld_pos_e      fld_pos,
  output logic          field_even,
  output logic          ilv_mode
);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOTAL - 1);

  logic field_end;
  assign field_end = line_end && (vcnt == V_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      vcnt       <= '0;
      fld_pos    <= FLD_FIRST;
      field_even <= even_first_i;
      ilv_mode   <= interleave_i;
    end else if (field_end) begin
      vcnt <= '0;
      if (fld_pos == FLD_SECOND) begin
        // frame boundary: take the new order and addressing mode
        fld_pos    <= FLD_FIRST;
        field_even <= even_first_i;
        ilv_mode   <= interleave_i;
      end else begin
        fld_pos    <= FLD_SECOND;
        field_even <= ~field_even;
      end
    end else if (line_end) begin
      vcnt <= vcnt + 1'b1;
    end
  end
endmodule

// File: rtl/ilace_decode.sv
module ilace_decode
  import ilace_pkg::*;
#(
  parameter int H_TOTAL      = 858,
  parameter int H_SYNC_W     = 64,
  parameter int H_ACT_START  = 122,
  parameter int H_ACT_W      = 720,
  parameter int V_ACT_START  = 18,
  parameter int ACT_LINES    = 240,
  parameter int V_SYNC_START = 259,
  parameter int V_SYNC_LINES = 2,
  parameter int HW           = 10,
  parameter int VW           = 9,
  parameter int LINE_W       = 9
) (
  input  logic [HW-1:0]     hcnt,
  input  logic [VW-1:0]     vcnt,
  input  fld_pos_e          fld_pos,
  input  logic              field_even,
  input  logic              ilv_mode,
  output logic              hsync,
  output logic              vsync,
  output logic              disp_act,
  output logic [LINE_W-1:0] src_line
);
  localparam logic [HW-1:0] HS_END  = HW'(H_SYNC_W);
  localparam logic [HW-1:0] HA_BEG  = HW'(H_ACT_START);
  localparam logic [HW-1:0] HA_END  = HW'(H_ACT_START + H_ACT_W);
  localparam logic [HW-1:0] H_HALF  = HW'(H_TOTAL / 2);
  localparam logic [VW-1:0] VA_BEG  = VW'(V_ACT_START);
  localparam logic [VW-1:0] VA_END  = VW'(V_ACT_START + ACT_LINES);
  localparam logic [VW-1:0] VS_LINE = VW'(V_SYNC_START);
  localparam logic [VW-1:0] VS_EARLY = VW'(V_SYNC_START - 1);
  localparam logic [VW-1:0] VS_LEN  = VW'(V_SYNC_LINES);

  logic [HW-1:0] vs_h0;
  logic [VW-1:0] vs_l0, vs_l1, vrel;
  logic          after_start, before_stop;

  // pulse start point: first field on the line edge, second field half a line off
  always_comb begin
    if (fld_pos == FLD_FIRST) begin
      vs_l0 = VS_LINE;
      vs_h0 = '0;
    end else begin
      vs_l0 = field_even ? VS_LINE : VS_EARLY;
      vs_h0 = H_HALF;
    end
    vs_l1 = vs_l0 + VS_LEN;
  end

  assign after_start = (vcnt > vs_l0) || ((vcnt == vs_l0) && (hcnt >= vs_h0));
  assign before_stop = (vcnt < vs_l1) || ((vcnt == vs_l1) && (hcnt < vs_h0));
  assign vsync       = after_start && before_stop;
  assign hsync       = (hcnt < HS_END);

  assign disp_act = (vcnt >= VA_BEG) && (vcnt < VA_END) &&
                    (hcnt >= HA_BEG) && (hcnt < HA_END);
  assign vrel     = vcnt - VA_BEG;

  always_comb begin
    if (!disp_act)     src_line = '0;
    else if (ilv_mode) src_line = {vrel[LINE_W-2:0], ~field_even};
    else               src_line = LINE_W'(vrel);
  end
endmodule

// File: rtl/ilace_timing_gen.sv
module ilace_timing_gen
  import ilace_pkg::*;
#(
  parameter int H_TOTAL      = 858,
  parameter int H_SYNC_W     = 64,
  parameter int H_ACT_START  = 122,
  parameter int H_ACT_W      = 720,
  parameter int V_TOTAL      = 262,
  parameter int V_ACT_START  = 18,
  parameter int ACT_LINES    = 240,
  parameter int V_SYNC_START = 259,
  parameter int V_SYNC_LINES = 2,
  parameter int LINE_W       = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              even_first_i,
  input  logic              interleave_i,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              field_even_o,
  output logic              disp_act_o,
  output logic [LINE_W-1:0] src_line_o
);
  localparam int HW = $clog2(H_TOTAL + 1);
  localparam int VW = $clog2(V_TOTAL + 1);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          line_end;
  fld_pos_e      fld_pos;
  logic          field_even;
  logic          ilv_mode;

  ilace_hcount #(.H_TOTAL(H_TOTAL), .HW(HW)) hcnt_i (
    .clk(clk), .rst(rst), .hcnt(hcnt), .line_end(line_end)
  );

  ilace_field_seq #(.V_TOTAL(V_TOTAL), .VW(VW)) fseq_i (
    .clk(clk), .rst(rst), .line_end(line_end),
    .even_first_i(even_first_i), .interleave_i(interleave_i),
    .vcnt(vcnt), .fld_pos(fld_pos), .field_even(field_even), .ilv_mode(ilv_mode)
  );

  ilace_decode #(
    .H_TOTAL(H_TOTAL), .H_SYNC_W(H_SYNC_W), .H_ACT_START(H_ACT_START),
    .H_ACT_W(H_ACT_W), .V_ACT_START(V_ACT_START), .ACT_LINES(ACT_LINES),
    .V_SYNC_START(V_SYNC_START), .V_SYNC_LINES(V_SYNC_LINES),
    .HW(HW), .VW(VW), .LINE_W(LINE_W)
  ) dec_i (
    .hcnt(hcnt), .vcnt(vcnt), .fld_pos(fld_pos), .field_even(field_even),
    .ilv_mode(ilv_mode), .hsync(hsync_o), .vsync(vsync_o),
    .disp_act(disp_act_o), .src_line(src_line_o)
  );

  assign field_even_o = field_even;
endmodule

// File: rtl/ilace_timing_chk.sv
module ilace_timing_chk #(
  parameter int H_TOTAL = 858,
  parameter int V_TOTAL = 262,
  parameter int HW      = 10,
  parameter int VW      = 9,
  parameter int LINE_W  = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              hsync,
  input logic              vsync,
  input logic              field_even,
  input logic              disp_act,
  input logic [LINE_W-1:0] src_line,
  input logic [HW-1:0]     hcnt,
  input logic [VW-1:0]     vcnt,
  input logic              second
);
  // R1
  pos_range_chk: assert property (@(posedge clk) disable iff (rst)
    (hcnt < HW'(H_TOTAL)) && (vcnt < VW'(V_TOTAL)));

  // R1
  hsync_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(hsync) |-> (hcnt == '0));

  // R2
  field_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ((hcnt != '0) || (vcnt != '0)) |-> $stable(field_even));

  // R2
  field_flip_chk: assert property (@(posedge clk) disable iff (rst)
    (second && !$past(second)) |-> (field_even != $past(field_even)));

  // R7
  vsync_blank_chk: assert property (@(posedge clk) disable iff (rst)
    vsync |-> !disp_act);

  // R11
  blank_zero_chk: assert property (@(posedge clk) disable iff (rst)
    !disp_act |-> (src_line == '0));
endmodule

bind ilace_timing_gen ilace_timing_chk #(
  .H_TOTAL(H_TOTAL), .V_TOTAL(V_TOTAL), .HW(HW), .VW(VW), .LINE_W(LINE_W)
) chk_i (
  .clk(clk), .rst(rst), .hsync(hsync_o), .vsync(vsync_o),
  .field_even(field_even_o), .disp_act(disp_act_o), .src_line(src_line_o),
  .hcnt(hcnt), .vcnt(vcnt), .second(fld_pos == ilace_pkg::FLD_SECOND)
);

// File: tb/ilace_timing_gen_tb.sv
module ilace_timing_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HT   = 20;
  localparam int HSW  = 3;
  localparam int HAS  = 4;
  localparam int HAW  = 12;
  localparam int VT   = 250;
  localparam int VAS  = 4;
  localparam int ACT  = 240;
  localparam int VDS  = 246;
  localparam int VSW  = 2;
  localparam int LW   = 9;
  localparam int NCYC = 62000;
  localparam int RST2 = 31000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic even_first = 1'b0;
  logic interleave = 1'b0;
  logic hsync, vsync, field_even, disp_act;
  logic [LW-1:0] src_line;

  int total = 0;
  int bad   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilace_timing_gen #(
    .H_TOTAL(HT), .H_SYNC_W(HSW), .H_ACT_START(HAS), .H_ACT_W(HAW),
    .V_TOTAL(VT), .V_ACT_START(VAS), .ACT_LINES(ACT),
    .V_SYNC_START(VDS), .V_SYNC_LINES(VSW), .LINE_W(LW)
  ) dut_i (
    .clk(clk), .rst(rst), .even_first_i(even_first), .interleave_i(interleave),
    .hsync_o(hsync), .vsync_o(vsync), .field_even_o(field_even),
    .disp_act_o(disp_act), .src_line_o(src_line)
  );

  task automatic check(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      if (bad <= 20)
        $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
    end
  endtask

  // reference state: pixel, line, second-field flag, field parity, mode
  int mh, mv;
  bit msec, meven, mmode, mvalid;

  initial begin : main
    mvalid = 0;
    for (int cyc = 0; cyc < NCYC; cyc++) begin
      @(negedge clk);
      rst = (cyc < 3) || (cyc >= RST2 && cyc < RST2 + 3);
      if (cyc < RST2) even_first = ((cyc / 7300) % 2) == 1;
      else            even_first = ((cyc / 7300) % 2) == 0;
      interleave = ((cyc / 13100) % 2) == 1;

      if (mvalid && !rst) begin
        int p, vs0, ln;
        bit act;
        if (cyc == 3 || cyc == RST2 + 3) begin
          // R12: state straight after reset
          check("R12 hsync after reset", int'(hsync), 1);
          check("R12 field after reset", int'(field_even), int'(meven));
          check("R12 active after reset", int'(disp_act), 0);
        end
        check("R1 hsync", int'(hsync), int'(mh < HSW));
        check("R2 R3 R4 field flag", int'(field_even), int'(meven));
        p   = mv * HT + mh;
        vs0 = VDS * HT + (msec ? (meven ? HT/2 : -(HT/2)) : 0);
        check(msec ? "R6 vsync second field" : "R5 vsync first field",
              int'(vsync), int'(p >= vs0 && p < vs0 + VSW * HT));
        act = (mv >= VAS) && (mv < VAS + ACT) && (mh >= HAS) && (mh < HAS + HAW);
        check("R7 display active", int'(disp_act), int'(act));
        ln = mv - VAS;
        if (!act)       check("R11 line idle", int'(src_line), 0);
        else if (mmode) check("R9 R10 interleave line", int'(src_line), 2 * ln + (meven ? 0 : 1));
        else            check("R8 R10 repeat line", int'(src_line), ln);
      end

      // advance reference to the state after the coming edge
      if (rst) begin
        mh = 0; mv = 0; msec = 0;
        meven = even_first; mmode = interleave; mvalid = 1;
      end else if (mvalid) begin
        mh++;
        if (mh == HT) begin
          mh = 0; mv++;
          if (mv == VT) begin
            mv = 0;
            if (msec) begin
              msec = 0; meven = even_first; mmode = interleave;
            end else begin
              msec = 1; meven = !meven;
            end
          end
        end
      end
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    #(CLK_PERIOD * 200000);
    bad++;
    total++;
    $display("FAIL watchdog expired: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule